// File: doc/BRIEF.md
# TDM Bit Clock and Frame Sync Generator

This block derives the serial bit clock and the frame sync of a time-division-multiplexed serial port from a faster system clock. A programmable divider sets the bit clock rate. A programmable frame length sets how many bit clocks make up one frame. The frame sync is an active-low pulse one bit period wide. A select input places it either on the bit clock rising edge that opens the frame, or half a bit period earlier, on the falling edge in the middle of the last bit of the previous frame. A one-cycle frame-start strobe in the system clock domain marks the cycle in which the sync goes low, so logic in that domain can align to frames without sampling the serial clock.

The bit clock period is 2 x (div_value + 1) system clocks. The high and low halves are equal. frame_len holds the number of bit clocks per frame minus one and must be at least 1. When the block is disabled it parks both outputs and reloads its counters. After enable, a low lead-in half period comes first, then the rising edge that opens bit 0 of the first frame. Divider and frame-length values are picked up only at frame boundaries. The sync placement select is intended to be changed only while the block is disabled. The enable input takes effect from the second system clock after reset is released.

Top module: `tdm_clkgen`

## Requirements
- R1: bclk has a period of 2 x (div_value + 1) system clocks, high for div_value + 1 clocks and then low for div_value + 1 clocks; div_value 0 gives a ratio of 2.
- R2: A frame spans frame_len + 1 bit clocks, so a sync pulse starts every 2 x (div_value + 1) x (frame_len + 1) system clocks.
- R3: With early_sync = 0, fsync_n is low for exactly one bit period, starting with the bclk rising edge that opens bit 0 of the frame and ending with the rising edge that opens bit 1.
- R4: With early_sync = 1, fsync_n is low for exactly one bit period, starting with the bclk falling edge in the middle of the last bit of a frame and ending with the falling edge in the middle of bit 0 of the next frame.
- R5: frame_start is high for exactly one system clock, in the cycle where fsync_n first shows low, and at no other time.
- R6: While enable is low (sampled at a clock edge), bclk is 0, fsync_n is 1 and frame_start is 0 after that edge; re-enabling at any point restarts the sequence of R7 from the beginning.
- R7: When enable is first seen high at edge E0, bclk stays low through edge E0 + div_value and first rises at edge E0 + div_value + 1, which opens bit 0 of the first frame; with early_sync = 1 the first sync pulse and frame_start begin at E0.
- R8: div_value and frame_len changed while enabled leave the current frame untouched and take effect from the next frame boundary (the rising edge opening bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low parks outputs and reloads counters |
| div_value | input | DIV_W | Half-period length minus one, in system clocks |
| frame_len | input | FLEN_W | Bit clocks per frame minus one (at least 1) |
| early_sync | input | 1 | 1 places the sync half a bit period early |
| bclk | output | 1 | Serial bit clock |
| fsync_n | output | 1 | Active-low frame sync, one bit period wide |
| frame_start | output | 1 | One system clock pulse as fsync_n goes low |

## Verification
The main function is run against a cycle-exact model for several divider and frame-length pairs. A divide ratio of 2 (div_value 0) checks the tightest half period. Odd and even divider values separate a correct half-period count from one that is off by one. A long frame (frame_len 1023) shows that the bit counter wraps at the full programmed length and not at a narrower width. The same settings are run with both sync placements, which tells a pulse opened on the rising edge from one opened on the falling edge half a bit earlier. Runs end at arbitrary points mid-frame and then restart, which shows that disabling parks the outputs and that a restart begins with a clean lead-in. A divider and length change made in the middle of a frame separates adoption at the boundary from immediate adoption.

// File: rtl/tdm_clkgen_pkg.sv
package tdm_clkgen_pkg;

  // Where the frame sync pulse is placed relative to the frame boundary.
  typedef enum logic {
    SYNC_AT_EDGE    = 1'b0,  // opens on the rising edge of bit 0
    SYNC_HALF_EARLY = 1'b1   // opens on the falling edge of the last bit
  } sync_place_e;

endpackage

// File: rtl/tdm_half_timer.sv
// Counts system clocks within one half of the bit clock and emits a tick
// on the cycle that closes the current half.
module tdm_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] reload_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // A parked counter sits at zero, so the first running cycle ticks.
  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= reload_val;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/tdm_bit_sequencer.sv
// Tracks which half of which bit the serial clock is in and flags the
// frame boundary (the rise that opens bit 0).
module tdm_bit_sequencer #(
  parameter int FLEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [FLEN_W-1:0] load_len,
  input  logic [FLEN_W-1:0] len_act,
  output logic              in_high,
  output logic [FLEN_W-1:0] bit_idx,
  output logic              rise,
  output logic              fall,
  output logic              boundary
);

  assign rise     = tick && !in_high;
  assign fall     = tick &&  in_high;
  assign boundary = rise && (bit_idx == len_act);

  // While parked, the sequencer pretends to sit in the high half of the
  // last bit, so the first tick becomes the lead-in falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_high <= 1'b1;
      bit_idx <= '0;
    end else if (!run) begin
      in_high <= 1'b1;
      bit_idx <= load_len;
    end else if (tick) begin
      in_high <= !in_high;
      if (rise) begin
        bit_idx <= boundary ? '0 : bit_idx + 1'b1;
      end
    end
  end

  // The bit index never runs past the active frame length.
  AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bit_idx <= len_act)); // R2

endmodule

// File: rtl/tdm_sync_gen.sv
// Drives the registered serial outputs from the half-bit events.
module tdm_sync_gen
  import tdm_clkgen_pkg::*;
#(
  parameter int FLEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rise,
  input  logic              fall,
  input  logic              boundary,
  input  logic [FLEN_W-1:0] bit_idx,
  input  logic [FLEN_W-1:0] len_act,
  input  sync_place_e       place,
  output logic              bclk,
  output logic              fsync_n,
  output logic              frame_start
);

  logic go_low;
  logic go_high;

  always_comb begin
    if (place == SYNC_HALF_EARLY) begin
      go_low  = fall && (bit_idx == len_act);
      go_high = fall && (bit_idx == '0);
    end else begin
      go_low  = boundary;
      go_high = rise && (bit_idx == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk        <= 1'b0;
      fsync_n     <= 1'b1;
      frame_start <= 1'b0;
    end else if (!run) begin
      bclk        <= 1'b0;
      fsync_n     <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      if (rise) begin
        bclk <= 1'b1;
      end else if (fall) begin
        bclk <= 1'b0;
      end
      if (go_low) begin
        fsync_n <= 1'b0;
      end else if (go_high) begin
        fsync_n <= 1'b1;
      end
      frame_start <= go_low;
    end
  end

  AST_START_ON_SYNC_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!fsync_n && $past(fsync_n))); // R5

  AST_SYNC_FALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync_n) |-> frame_start); // R5

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bclk && fsync_n && !frame_start)); // R6

endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
  import tdm_clkgen_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int FLEN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div_value,
  input  logic [FLEN_W-1:0] frame_len,
  input  logic              early_sync,
  output logic              bclk,
  output logic              fsync_n,
  output logic              frame_start
);

  logic              armed_q;
  logic              run;
  logic [DIV_W-1:0]  div_act;
  logic [FLEN_W-1:0] len_act;
  sync_place_e       place_act;
  logic [DIV_W-1:0]  reload_val;
  logic              tick;
  logic              in_high;
  logic [FLEN_W-1:0] bit_idx;
  logic              rise;
  logic              fall;
  logic              boundary;

  // One parked cycle after reset so the counters hold the loaded values.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  assign run = enable && armed_q;

  // Active settings: track the inputs while parked, resample at boundaries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act   <= '0;
      len_act   <= '0;
      place_act <= SYNC_AT_EDGE;
    end else if (!run || boundary) begin
      div_act   <= div_value;
      len_act   <= frame_len;
      place_act <= sync_place_e'(early_sync);
    end
  end

  // The half that starts at a boundary already uses the new divider.
  assign reload_val = boundary ? div_value : div_act;

  tdm_half_timer #(
    .DIV_W (DIV_W)
  ) u_half_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .reload_val (reload_val),
    .tick       (tick)
  );

  tdm_bit_sequencer #(
    .FLEN_W (FLEN_W)
  ) u_bit_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .load_len (frame_len),
    .len_act  (len_act),
    .in_high  (in_high),
    .bit_idx  (bit_idx),
    .rise     (rise),
    .fall     (fall),
    .boundary (boundary)
  );

  tdm_sync_gen #(
    .FLEN_W (FLEN_W)
  ) u_sync_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .rise        (rise),
    .fall        (fall),
    .boundary    (boundary),
    .bit_idx     (bit_idx),
    .len_act     (len_act),
    .place       (place_act),
    .bclk        (bclk),
    .fsync_n     (fsync_n),
    .frame_start (frame_start)
  );

  // The bit clock only moves on a half-period tick.
  AST_BCLK_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(bclk)); // R1

  // Each rising edge of the bit clock follows a low half.
  AST_RISE_FROM_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !bclk); // R1

  // Active settings do not move inside a running frame.
  AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !boundary) |=> ($stable(div_act) && $stable(len_act))); // R8

endmodule

// File: tb/tdm_clkgen_bench.sv
module tdm_clkgen_bench;

  localparam int DW = 8;
  localparam int LW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable;
  logic [DW-1:0] div_value;
  logic [LW-1:0] frame_len;
  logic          early_sync;
  logic          bclk;
  logic          fsync_n;
  logic          frame_start;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #5 clk = ~clk;

  tdm_clkgen #(.DIV_W(DW), .FLEN_W(LW)) u_tdm_clkgen (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .div_value   (div_value),
    .frame_len   (frame_len),
    .early_sync  (early_sync),
    .bclk        (bclk),
    .fsync_n     (fsync_n),
    .frame_start (frame_start)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s @%0t actual=%0d expected=%0d", req, what, $time, act, exp);
    end
  endtask

  // Expected outputs t cycles after the enable edge. tb is the cycle of the
  // boundary that opens the current frame segment (d, l apply from there).
  task automatic expect_at(input int t, input int tb, input int d, input int l,
                           input bit early, output bit eb, output bit ef, output bit es);
    int q, h, hf, fr;
    fr = 2 * (l + 1);
    if (t < tb) begin
      // lead-in low half before the first frame
      eb = 1'b0;
      ef = !early;
      es = early && (t == tb - (d + 1));
    end else begin
      q  = t - tb;
      h  = q / (d + 1);
      hf = h % fr;
      eb = (h % 2) == 0;
      if (early) begin
        ef = !((hf == 0) || (hf == fr - 1));
        es = ((q % (d + 1)) == 0) && (hf == fr - 1);
      end else begin
        ef = !((hf == 0) || (hf == 1));
        es = ((q % (d + 1)) == 0) && (hf == 0);
      end
    end
  endtask

  task automatic check_cycle(input int t, input int tb, input int d, input int l, input bit early);
    bit eb, ef, es;
    expect_at(t, tb, d, l, early, eb, ef, es);
    if (t < tb) begin
      chk("R7", "lead-in bclk", int'(bclk), int'(eb));
      chk("R7", "lead-in fsync_n", int'(fsync_n), int'(ef));
    end else begin
      chk("R1", "bclk", int'(bclk), int'(eb));
      chk(early ? "R4" : "R2/R3", "fsync_n", int'(fsync_n), int'(ef));
    end
    chk("R5", "frame_start", int'(frame_start), int'(es));
  endtask

  task automatic check_idle(input string tag);
    chk("R6", {tag, " bclk"}, int'(bclk), 0);
    chk("R6", {tag, " fsync_n"}, int'(fsync_n), 1);
    chk("R6", {tag, " frame_start"}, int'(frame_start), 0);
  endtask

  // Disable at a negedge and confirm the outputs park after the next edge.
  task automatic stop_and_check();
    enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_idle("parked");
    end
  endtask

  // R1-R5, R7: one run from enable, checked every cycle.
  task automatic t_run(input int d, input int l, input bit early, input int nframes, input int extra);
    int tb, total;
    div_value  = DW'(d);
    frame_len  = LW'(l);
    early_sync = early;
    @(negedge clk);
    enable = 1'b1;
    tb    = d + 1;
    total = tb + nframes * 2 * (d + 1) * (l + 1) + extra;
    for (int t = 0; t < total; t++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(t, tb, d, l, early);
    end
    stop_and_check();
  endtask

  // R8: settings changed mid-frame are adopted at the next boundary only.
  task automatic t_midchange();
    int d1, l1, d2, l2, tb1, tb2, total;
    d1 = 3; l1 = 3; d2 = 1; l2 = 5;
    div_value  = DW'(d1);
    frame_len  = LW'(l1);
    early_sync = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    tb1   = d1 + 1;
    tb2   = tb1 + 2 * (d1 + 1) * (l1 + 1);
    total = tb2 + 2 * 2 * (d2 + 1) * (l2 + 1) + 5;
    for (int t = 0; t < total; t++) begin
      @(posedge clk);
      @(negedge clk);
      if (t < tb2) begin
        check_cycle(t, tb1, d1, l1, 1'b0);
      end else begin
        bit eb, ef, es;
        expect_at(t, tb2, d2, l2, 1'b0, eb, ef, es);
        chk("R8", "bclk after boundary", int'(bclk), int'(eb));
        chk("R8", "fsync_n after boundary", int'(fsync_n), int'(ef));
        chk("R8", "frame_start after boundary", int'(frame_start), int'(es));
      end
      if (t == tb1 + 10) begin
        div_value = DW'(d2);
        frame_len = LW'(l2);
      end
    end
    stop_and_check();
  endtask

  // R6: reset and parked state.
  task automatic t_reset();
    rst_n      = 1'b0;
    enable     = 1'b0;
    div_value  = DW'(3);
    frame_len  = LW'(7);
    early_sync = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("in reset");
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check_idle("disabled after reset");
    end
  endtask

  initial begin
    t_reset();
    t_run(3, 7, 1'b0, 3, 7);      // R3 reference rate, normal placement
    t_run(3, 7, 1'b1, 3, 11);     // R4 same rate, early placement (restart: R6)
    t_run(0, 1, 1'b0, 4, 3);      // R1 divide ratio of two
    t_run(0, 1, 1'b1, 4, 2);      // R4 early at ratio two
    t_run(2, 3, 1'b1, 3, 5);      // R1 odd half length
    t_run(1, 1023, 1'b0, 2, 9);   // R2 long frame
    t_run(5, 2, 1'b1, 2, 0);      // R7 early pulse at enable
    t_midchange();                // R8
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule